// File: doc/BRIEF.md
# Deserializer-Word Time-to-Digital Converter

This block timestamps one digital pulse and measures its width at sub-clock resolution. Its input is a stream of 16-bit parallel words, one per reference clock period, each word being 16 time-ordered samples of the detector line. The most significant bit holds the earliest sample. At a 6.4 ns word period a single bit stands for 400 ps.

Once armed, the block looks for the first word that holds a high sample. It latches the value of a word-period coarse counter for that word and a fine offset, which is the number of low samples ahead of the first high one. It then counts consecutive high samples, across word boundaries if needed, until the first low sample appears. Arrival time is coarse × 6.4 ns + fine × 400 ps, and width is samples × 400 ps, with an uncertainty of half a sample. One pulse is captured per arm. A pulse that is still high after a set number of words is reported with an overflow flag.

Top module: `word_tdc`

## Requirements
- R1: After reset, coarse_o, fine_o, width_o, overflow_o and result_valid_o are 0, and no result is produced until arm_i has been pulsed, even when words containing high samples arrive.
- R2: fine_o equals the number of zero bits above the highest set bit of the word holding the leading edge. Bit 15 is the earliest sample, so 0xFFFF gives 0, 0x7FFF gives 1 and 0x0001 gives 15.
- R3: An internal 16-bit coarse counter is cleared by arm_i and advances by one for each accepted word. coarse_o reports its value for the word holding the leading edge, so the first word after arming is 0.
- R4: A word with no set bit produces no result and advances the coarse count. A pulse starting at bit 15 of the next word reports fine 0 and a coarse value one higher.
- R5: width_o is the count of consecutive high samples from the leading edge, continued across word boundaries. For example, 0x07FF followed by 0xFFC0 gives 21.
- R6: Pulses that both start and end inside one word are measured (11, 3 and 1 samples). Set bits that follow the first zero after the run are ignored.
- R7: result_valid_o is high for exactly one clock, in the cycle after the clock edge that accepts the word containing the trailing edge (its first zero).
- R8: After a result, further pulses are ignored and all outputs hold their values until arm_i is pulsed again.
- R9: If a pulse has not ended within MAX_WORDS accepted words, counting the start word, a result is produced after that word with overflow_o = 1 and width_o = MAX_WORDS × 16 − fine. Otherwise overflow_o is 0.
- R10: A cycle with valid_i low is ignored: its word is not examined and the coarse count does not advance.
- R11: In a cycle with arm_i high, the word is not examined, even if valid_i is high, and the coarse count restarts at 0 for the next accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word-rate reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arms the capture and clears the coarse counter |
| valid_i | input | 1 | Qualifies word_i in this cycle |
| word_i | input | 16 | Deserialized samples, bit 15 earliest |
| coarse_o | output | 16 | Word count at the leading edge |
| fine_o | output | 4 | Zero samples before the leading edge within its word |
| width_o | output | 7 | Pulse width in samples |
| overflow_o | output | 1 | The pulse did not end within MAX_WORDS words |
| result_valid_o | output | 1 | One-cycle strobe when a new result is presented |

## Verification
The hardest case to reach is a run that crosses word boundaries and ends, or fails to end, exactly at the MAX_WORDS limit. It matters whether the first zero falls in the last allowed word or one word after it, and the fine offset shifts that boundary. The stimulus builds each word stream from a chosen start sample and width, sample by sample. Table entries put the end exactly on a word edge (widths 48 and 64 from sample 0) or one word past the limit. Pseudo-random start and width pairs then sweep the remaining offsets against a model that computes coarse, fine, width and overflow.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_RUN  = 2'd2
  } tdc_state_e;
endpackage

// File: rtl/tdc_lead_cnt.sv
// Leading-zero count from MSB; returns W for an all-zero input.
module tdc_lead_cnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/word_tdc.sv
module word_tdc #(
  parameter int WORD_W    = 16,
  parameter int COARSE_W  = 16,
  parameter int MAX_WORDS = 4,
  localparam int FINE_W   = $clog2(WORD_W),
  localparam int WIDTH_W  = $clog2(MAX_WORDS * WORD_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                valid_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [WIDTH_W-1:0]  width_o,
  output logic                overflow_o,
  output logic                result_valid_o
);
  import tdc_pkg::*;

  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int RUNW_W = $clog2(MAX_WORDS + 1);
  localparam logic [CNT_W:0]    WORD_N = (CNT_W + 1)'(WORD_W);
  localparam logic [RUNW_W-1:0] RUN_MAX = RUNW_W'(MAX_WORDS);

  tdc_state_e              state_q;
  logic [COARSE_W-1:0]     coarse_q;
  logic [WIDTH_W-1:0]      width_acc_q;
  logic [RUNW_W-1:0]       run_words_q;

  logic                    take;
  logic                    seek;
  logic                    word_hit;
  logic [CNT_W-1:0]        lz;
  logic [CNT_W-1:0]        shamt;
  logic [WORD_W-1:0]       shifted;
  logic [CNT_W-1:0]        lo;
  logic                    ends;
  logic [WIDTH_W-1:0]      width_sum;
  logic [RUNW_W-1:0]       words_nx;
  logic                    ovf_now;
  logic                    finish;

  tdc_coarse_ctr #(.CW(COARSE_W)) i_coarse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .inc_i  (take),
    .cnt_o  (coarse_q)
  );

  // leading edge position
  tdc_lead_cnt #(.W(WORD_W), .CW(CNT_W)) i_lead_zero (
    .d_i   (word_i),
    .cnt_o (lz)
  );

  // run of ones starting at the edge (or at MSB while running)
  tdc_lead_cnt #(.W(WORD_W), .CW(CNT_W)) i_lead_one (
    .d_i   (~shifted),
    .cnt_o (lo)
  );

  assign take     = valid_i && !arm_i;
  assign seek     = (state_q == ST_SEEK);
  assign word_hit = |word_i;
  assign shamt    = seek ? lz : '0;
  assign shifted  = word_i << shamt;
  assign ends     = ({1'b0, shamt} + {1'b0, lo}) < WORD_N;
  assign width_sum = (seek ? '0 : width_acc_q) + WIDTH_W'(lo);
  assign words_nx = seek ? RUNW_W'(1) : run_words_q + 1'b1;
  assign ovf_now  = !ends && (words_nx == RUN_MAX);
  assign finish   = take && ((seek && word_hit) || state_q == ST_RUN)
                    && (ends || ovf_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      width_acc_q    <= '0;
      run_words_q    <= '0;
      coarse_o       <= '0;
      fine_o         <= '0;
      width_o        <= '0;
      overflow_o     <= 1'b0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      if (arm_i) begin
        state_q <= ST_SEEK;
      end else if (take && (state_q == ST_RUN || (seek && word_hit))) begin
        if (seek) begin
          coarse_o <= coarse_q;
          fine_o   <= lz[FINE_W-1:0];
        end
        if (finish) begin
          width_o        <= width_sum;
          overflow_o     <= ovf_now;
          result_valid_o <= 1'b1;
          state_q        <= ST_IDLE;
        end else begin
          width_acc_q <= width_sum;
          run_words_q <= words_nx;
          state_q     <= ST_RUN;
        end
      end
    end
  end
endmodule

// File: rtl/word_tdc_chk.sv
module word_tdc_chk #(
  parameter int WORD_W    = 16,
  parameter int COARSE_W  = 16,
  parameter int MAX_WORDS = 4,
  localparam int FINE_W   = $clog2(WORD_W),
  localparam int WIDTH_W  = $clog2(MAX_WORDS * WORD_W + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                arm_i,
  input logic                valid_i,
  input logic [COARSE_W-1:0] coarse_q,
  input logic [WIDTH_W-1:0]  width_o,
  input logic                overflow_o,
  input logic                result_valid_o
);
  // R7
  rv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  // R10
  rv_needs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_valid_o) |-> $past(valid_i) && !$past(arm_i));

  // R11
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> coarse_q == '0);

  // R3
  coarse_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !arm_i) |=> coarse_q == $past(coarse_q) + 1'b1);

  // R10
  coarse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !arm_i) |=> $stable(coarse_q));

  // R5
  width_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> width_o >= 1 && width_o <= WIDTH_W'(MAX_WORDS * WORD_W));

  // R9
  ovf_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && overflow_o) |-> width_o > WIDTH_W'((MAX_WORDS - 1) * WORD_W));
endmodule

bind word_tdc word_tdc_chk #(
  .WORD_W(WORD_W), .COARSE_W(COARSE_W), .MAX_WORDS(MAX_WORDS)
) i_word_tdc_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .arm_i          (arm_i),
  .valid_i        (valid_i),
  .coarse_q       (coarse_q),
  .width_o        (width_o),
  .overflow_o     (overflow_o),
  .result_valid_o (result_valid_o)
);

// File: tb/test_word_tdc.sv
module test_word_tdc;
  localparam int MAXW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] word = '0;
  logic [15:0] coarse;
  logic [3:0]  fine;
  logic [6:0]  width;
  logic        ovf;
  logic        rv;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  word_tdc i_word_tdc (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .valid_i(valid), .word_i(word),
    .coarse_o(coarse), .fine_o(fine), .width_o(width), .overflow_o(ovf),
    .result_valid_o(rv)
  );

  // start sample, width, coarse, fine, width, overflow
  localparam int TBL[13][6] = '{
    '{0, 21, 0, 0, 21, 0},    // R2 R5
    '{1, 21, 0, 1, 21, 0},    // R2
    '{2, 21, 0, 2, 21, 0},
    '{4, 21, 0, 4, 21, 0},
    '{15, 21, 0, 15, 21, 0},  // R2
    '{16, 21, 1, 0, 21, 0},   // R4
    '{4, 11, 0, 4, 11, 0},    // R6
    '{4, 3, 0, 4, 3, 0},      // R6
    '{4, 1, 0, 4, 1, 0},      // R6
    '{36, 40, 2, 4, 40, 0},   // R3 R5
    '{5, 70, 0, 5, 59, 1},    // R9
    '{0, 48, 0, 0, 48, 0},    // R9 boundary
    '{0, 64, 0, 0, 64, 1}     // R9 boundary
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(int k, int s, int w);
    logic [15:0] r = '0;
    for (int b = 0; b < 16; b++) begin
      int smp = k * 16 + (15 - b);
      r[b] = (smp >= s) && (smp < s + w);
    end
    return r;
  endfunction

  task automatic do_arm();
    @(negedge clk); arm = 1'b1; valid = 1'b0;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic run_case(input int s, input int w, input int ec, input int ef,
                          input int ew, input int eo);
    int ws = s / 16;
    int n = ws + MAXW + 1;
    int we = (s + w) / 16;
    int eidx = (we - ws + 1 > MAXW) ? ws + MAXW - 1 : we;
    int hits = 0;
    int idx = -1;
    do_arm();
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (rv) begin
        hits++;
        if (idx < 0) idx = k - 1;
        chk(coarse == 16'(ec), "R3 coarse", int'(coarse), ec);
        chk(fine == 4'(ef), "R2 fine", int'(fine), ef);
        chk(width == 7'(ew), "R5 width", int'(width), ew);
        chk(ovf == 1'(eo), "R9 overflow", int'(ovf), eo);
      end
      valid = (k < n);
      word = mk_word(k, s, w);
    end
    valid = 1'b0;
    chk(hits == 1, "R7 one result", hits, 1);
    chk(idx == eidx, "R7 timing", idx, eidx);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] w_hold;
    bit seen;
    repeat (3) @(negedge clk);
    chk(coarse == 0 && fine == 0 && width == 0 && ovf == 0 && rv == 0,
        "R1 reset outputs", int'(width), 0);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); valid = 1'b1; word = (k == 3) ? 16'h0000 : 16'hF0F0;
      if (rv) seen = 1;
    end
    @(negedge clk); valid = 1'b0; if (rv) seen = 1;
    @(negedge clk); if (rv) seen = 1;
    chk(!seen && width == 0, "R1 no result before arm", int'(seen), 0);

    foreach (TBL[i])
      run_case(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4], TBL[i][5]);

    // R8: further pulse without re-arm is ignored
    w_hold = width;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); valid = 1'b1; word = (k == 0) ? 16'h0F00 : 16'h0000;
      if (rv) seen = 1;
    end
    @(negedge clk); valid = 1'b0; if (rv) seen = 1;
    @(negedge clk); if (rv) seen = 1;
    chk(!seen && width == w_hold, "R8 ignored after result", int'(width), int'(w_hold));

    // R10: invalid cycles ignored (data and coarse)
    do_arm();
    @(negedge clk); valid = 1'b0; word = 16'hFFFF;
    @(negedge clk); valid = 1'b1; word = 16'h0000;
    @(negedge clk); valid = 1'b1; word = 16'h000F;
    @(negedge clk); valid = 1'b0; word = 16'h0000;
    @(negedge clk); valid = 1'b1; word = 16'hFFFF;
    @(negedge clk); valid = 1'b1; word = 16'h0000;
    @(negedge clk); valid = 1'b0;
    chk(rv == 1'b1, "R10 result strobe", int'(rv), 1);
    chk(coarse == 1 && fine == 12, "R10 coarse/fine", int'(coarse), 1);
    chk(width == 20, "R10 width across gap", int'(width), 20);

    // R11: word in arm cycle not examined, coarse restarts
    @(negedge clk); arm = 1'b1; valid = 1'b1; word = 16'hFFFF;
    @(negedge clk); arm = 1'b0; valid = 1'b1; word = 16'h00F0;
    @(negedge clk); valid = 1'b0;
    chk(rv == 1'b1 && coarse == 0, "R11 coarse restart", int'(coarse), 0);
    chk(fine == 8 && width == 4, "R11 arm word skipped", int'(fine), 8);

    // pseudo-random sweep against model
    for (int t = 0; t < 16; t++) begin
      int s = $urandom_range(47, 0);
      int w = $urandom_range(70, 1);
      int ws = s / 16;
      int f = s % 16;
      int we = (s + w) / 16;
      bit o = (we - ws + 1) > MAXW;
      run_case(s, w, ws, f, o ? MAXW * 16 - f : w, int'(o));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule